// File: doc/BRIEF.md
# Phase Current Unbalance Estimator

This block takes one record of ripple samples, measured across a switching period of a multi-phase buck converter, and turns it into one current-unbalance figure per phase. A record holds twice as many samples as there are phases. The block reads the record from an external sample buffer and multiplies it by a fixed real coefficient matrix with a single multiplier, one row per phase. It then passes each row result through a first-order low-pass filter before publishing it. Because the unbalance drifts slowly, a controller starts an estimate only now and then, for example once per filter update tick. It does not run one every switching period.

Each estimate uses one of a small bank of coefficient sets, and the caller picks the set to match the duty-cycle band in which the record was taken. The coefficients of every set are arranged so that each phase figure is a deviation from the phase average: with smoothing off and no clipping, the figures of one estimate add up to zero. The controller also picks the filter strength for each estimate with a shift amount. The filter output moves toward the new raw figure by the difference divided by a power of two.

Top module: `phase_unbal_est`

## Requirements
- R1: While reset is asserted and after its release, until the first estimate completes, every phase output is zero and both `busy` and `done` are low.
- R2: With N phases and K = 2N samples, the raw figure of phase r equals the sum over columns c of coef(b,r,c) times sample c, where b is the chosen band. Here seed(b,r,c) = (37b + 23r + 11c + 5rc) mod 128 and coef(b,r,c) = seed(b,r,c) - seed(b,(r+1) mod N,c). The coefficients are signed fixed-point integers.
- R3: Every addition into a row accumulator saturates to the largest positive or most negative value of the AW-bit signed range and never wraps. The additions are taken in ascending column order.
- R4: The band select and the shift amount are captured in the cycle a start is accepted. Later changes to them have no effect on that estimate.
- R5: On each estimate every phase output y becomes y + ((raw - y) arithmetically shifted right by S), where S is the captured shift. With S = 0 the output equals the raw figure.
- R6: `done` is high for exactly one cycle, and it rises NK + 2 clock edges after the edge that accepted the start. All N outputs take their new values on that same edge and hold them at every other time.
- R7: A start that arrives while `busy` is high is ignored: it neither restarts nor extends the running estimate.
- R8: For every band, each coefficient column sums to zero over the phases. With S = 0 and no saturation, the N outputs of an estimate therefore sum to zero.
- R9: `busy` is high for the NK + 2 cycles that follow an accepted start and is low in the cycle in which `done` is high.
- R10: During the NK cycles that follow an accepted start, the sample address runs 0, 1, …, K-1 once for each phase row in turn. The buffer returns the addressed sample one cycle later.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous reset, active low |
| start | input | 1 | Request one estimate; taken only when idle |
| bandSel | input | clog2(NBAND) | Duty-cycle band that selects the coefficient set |
| shiftSel | input | SHW | Filter shift S |
| sampAddr | output | clog2(2N) | Sample buffer read address |
| sampData | input | SW | Signed sample returned one cycle after its address |
| busy | output | 1 | Estimate in progress |
| done | output | 1 | One-cycle pulse when all outputs were updated |
| estOut | output | N*AW | Filtered signed phase figures, phase p at bits p*AW upward |

## Verification
After the start edge, address k of the sweep is due in the cycle that follows k edges, for k below NK. `busy` must stay high through cycle NK+1, and `done` together with the new outputs is due after exactly NK + 2 edges. The bench drives its inputs on the falling edge and reads every result on the falling edge that follows the edge that was counted, so each expected value is compared in the single cycle the requirements assign to it. The bench computes the expected raw figures, the saturation and the filter response with its own arithmetic. It sweeps every band with several sample patterns and every shift value.

// File: rtl/ue_pkg.sv
package ue_pkg;

  typedef enum logic [1:0] {
    ST_IDLE,
    ST_RUN,
    ST_DRAIN,
    ST_FILT
  } ueState_e;

  // index field width used by the strobe bundle (covers up to 255 rows/columns)
  localparam int IDX_W = 8;

  typedef struct packed {
    logic             clrAcc;
    logic             macEn;
    logic [IDX_W-1:0] macRow;
    logic [IDX_W-1:0] macCol;
    logic             filtEn;
  } ueStrobe_t;

  // seed used to derive the coefficient constants
  function automatic int coefSeed(input int band, input int row, input int col);
    return (band * 37 + row * 23 + col * 11 + row * col * 5) % 128;
  endfunction

endpackage

// File: rtl/ue_coef_bank.sv
module ue_coef_bank
  import ue_pkg::*;
#(
  parameter int NPH   = 3,
  parameter int NBAND = 4,
  parameter int CW    = 8,
  localparam int NS   = 2 * NPH,
  localparam int BW   = (NBAND > 1) ? $clog2(NBAND) : 1,
  localparam int TOTAL = NBAND * NPH * NS
) (
  input  logic [BW-1:0]        band,
  input  logic [IDX_W-1:0]     row,
  input  logic [IDX_W-1:0]     col,
  output logic signed [CW-1:0] coef
);

  logic signed [CW-1:0] coefRom [TOTAL];

  // constant coefficient sets, one per duty band; columns sum to zero per band
  for (genvar b = 0; b < NBAND; b++) begin : gBand
    for (genvar r = 0; r < NPH; r++) begin : gRow
      for (genvar c = 0; c < NS; c++) begin : gCol
        localparam int VAL = coefSeed(b, r, c) - coefSeed(b, (r + 1) % NPH, c);
        localparam logic [31:0] VBITS = VAL;
        assign coefRom[(b * NPH + r) * NS + c] = VBITS[CW-1:0];
      end
    end
  end

  int idx;
  always_comb begin
    idx  = (int'(band) * NPH + int'(row)) * NS + int'(col);
    coef = '0;
    for (int i = 0; i < TOTAL; i++) begin
      if (i == idx) coef = coefRom[i];
    end
  end

endmodule

// File: rtl/ue_phase_filter.sv
module ue_phase_filter #(
  parameter int AW  = 18,
  parameter int SHW = 3
) (
  input  logic                 clk,
  input  logic                 rstN,
  input  logic                 en,
  input  logic [SHW-1:0]       shift,
  input  logic signed [AW-1:0] raw,
  output logic signed [AW-1:0] y
);

  logic signed [AW:0] diff;
  logic signed [AW:0] step;

  always_comb begin
    diff = (AW+1)'(raw) - (AW+1)'(y);
    step = diff >>> shift;
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      y <= '0;
    end else if (en) begin
      y <= y + step[AW-1:0];
    end
  end

  AST_FILT_PASS: assert property (@(posedge clk) disable iff (!rstN)
    (en && shift == '0) |=> (y == $past(raw))); // R5

  AST_OUT_HOLD: assert property (@(posedge clk) disable iff (!rstN)
    !en |=> $stable(y)); // R6

endmodule

// File: rtl/ue_control.sv
module ue_control
  import ue_pkg::*;
#(
  parameter int NPH   = 3,
  parameter int NBAND = 4,
  parameter int SHW   = 3,
  localparam int NS   = 2 * NPH,
  localparam int BW   = (NBAND > 1) ? $clog2(NBAND) : 1,
  localparam int ADW  = $clog2(NS)
) (
  input  logic           clk,
  input  logic           rstN,
  input  logic           start,
  input  logic [BW-1:0]  bandSel,
  input  logic [SHW-1:0] shiftSel,
  output ueStrobe_t      strobe,
  output logic [BW-1:0]  cfgBand,
  output logic [SHW-1:0] cfgShift,
  output logic [ADW-1:0] sampAddr,
  output logic           busy,
  output logic           done
);

  localparam logic [IDX_W-1:0] LAST_COL = IDX_W'(NS - 1);
  localparam logic [IDX_W-1:0] LAST_ROW = IDX_W'(NPH - 1);

  ueState_e         state;
  logic [IDX_W-1:0] issueRow;
  logic [IDX_W-1:0] issueCol;
  logic             pValid;
  logic [IDX_W-1:0] pRow;
  logic [IDX_W-1:0] pCol;
  logic             accept;

  assign accept = start && (state == ST_IDLE);
  assign busy   = (state != ST_IDLE);
  assign sampAddr = (state == ST_RUN) ? ADW'(issueCol) : '0;

  always_comb begin
    strobe.clrAcc = accept;
    strobe.macEn  = pValid;
    strobe.macRow = pRow;
    strobe.macCol = pCol;
    strobe.filtEn = (state == ST_FILT);
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      state    <= ST_IDLE;
      issueRow <= '0;
      issueCol <= '0;
      pValid   <= 1'b0;
      pRow     <= '0;
      pCol     <= '0;
      cfgBand  <= '0;
      cfgShift <= '0;
      done     <= 1'b0;
    end else begin
      // sample read latency stage: data for the issued address arrives next cycle
      pValid <= (state == ST_RUN);
      pRow   <= issueRow;
      pCol   <= issueCol;
      done   <= (state == ST_FILT);
      unique case (state)
        ST_IDLE: begin
          if (start) begin
            state    <= ST_RUN;
            issueRow <= '0;
            issueCol <= '0;
            cfgBand  <= bandSel;
            cfgShift <= shiftSel;
          end
        end
        ST_RUN: begin
          if (issueCol == LAST_COL) begin
            issueCol <= '0;
            if (issueRow == LAST_ROW) state <= ST_DRAIN;
            else issueRow <= issueRow + IDX_W'(1);
          end else begin
            issueCol <= issueCol + IDX_W'(1);
          end
        end
        ST_DRAIN: state <= ST_FILT;
        ST_FILT:  state <= ST_IDLE;
        default:  state <= ST_IDLE;
      endcase
    end
  end

  AST_DONE_PULSE: assert property (@(posedge clk) disable iff (!rstN)
    done |=> !done); // R6

  AST_START_IGNORED: assert property (@(posedge clk) disable iff (!rstN)
    (state == ST_RUN && start && issueCol != LAST_COL)
      |=> (issueCol == $past(issueCol) + IDX_W'(1))); // R7

  AST_CFG_HELD: assert property (@(posedge clk) disable iff (!rstN)
    busy |=> ($stable(cfgBand) && $stable(cfgShift))); // R4

  AST_ADDR_RANGE: assert property (@(posedge clk) disable iff (!rstN)
    busy |-> (int'(sampAddr) < NS)); // R10

  AST_NOT_BUSY_AT_DONE: assert property (@(posedge clk) disable iff (!rstN)
    done |-> !busy); // R9

endmodule

// File: rtl/ue_datapath.sv
module ue_datapath
  import ue_pkg::*;
#(
  parameter int NPH   = 3,
  parameter int NBAND = 4,
  parameter int SW    = 10,
  parameter int CW    = 8,
  parameter int AW    = 18,
  parameter int SHW   = 3,
  localparam int BW   = (NBAND > 1) ? $clog2(NBAND) : 1,
  localparam int PW   = SW + CW,
  localparam int SUMW = ((PW > AW) ? PW : AW) + 1
) (
  input  logic                 clk,
  input  logic                 rstN,
  input  ueStrobe_t            strobe,
  input  logic [BW-1:0]        cfgBand,
  input  logic [SHW-1:0]       cfgShift,
  input  logic signed [SW-1:0] sampData,
  output logic [NPH*AW-1:0]    estFlat
);

  localparam logic signed [AW-1:0]   ACC_MAX = {1'b0, {(AW-1){1'b1}}};
  localparam logic signed [AW-1:0]   ACC_MIN = {1'b1, {(AW-1){1'b0}}};
  localparam logic signed [SUMW-1:0] SAT_HI  = SUMW'(ACC_MAX);
  localparam logic signed [SUMW-1:0] SAT_LO  = SUMW'(ACC_MIN);

  logic signed [CW-1:0]   coef;
  logic signed [PW-1:0]   prod;
  logic signed [AW-1:0]   acc [NPH];
  logic signed [AW-1:0]   accSel;
  logic signed [SUMW-1:0] sumExt;
  logic signed [AW-1:0]   accNext;

  ue_coef_bank #(
    .NPH  (NPH),
    .NBAND(NBAND),
    .CW   (CW)
  ) uCoef (
    .band(cfgBand),
    .row (strobe.macRow),
    .col (strobe.macCol),
    .coef(coef)
  );

  // single shared multiplier and saturating adder
  always_comb begin
    prod   = PW'(sampData) * PW'(coef);
    accSel = '0;
    for (int r = 0; r < NPH; r++) begin
      if (strobe.macRow == IDX_W'(r)) accSel = acc[r];
    end
    sumExt = SUMW'(accSel) + SUMW'(prod);
    if (sumExt > SAT_HI)      accNext = ACC_MAX;
    else if (sumExt < SAT_LO) accNext = ACC_MIN;
    else                      accNext = sumExt[AW-1:0];
  end

  for (genvar r = 0; r < NPH; r++) begin : gAcc
    always_ff @(posedge clk or negedge rstN) begin
      if (!rstN) begin
        acc[r] <= '0;
      end else if (strobe.clrAcc) begin
        acc[r] <= '0;
      end else if (strobe.macEn && strobe.macRow == IDX_W'(r)) begin
        acc[r] <= accNext;
      end
    end

    ue_phase_filter #(
      .AW (AW),
      .SHW(SHW)
    ) uFilt (
      .clk  (clk),
      .rstN (rstN),
      .en   (strobe.filtEn),
      .shift(cfgShift),
      .raw  (acc[r]),
      .y    (estFlat[r*AW +: AW])
    );

    AST_SAT_HIGH: assert property (@(posedge clk) disable iff (!rstN)
      (strobe.macEn && !strobe.clrAcc && strobe.macRow == IDX_W'(r)
        && acc[r] == ACC_MAX && prod >= 0) |=> (acc[r] == ACC_MAX)); // R3

    AST_SAT_LOW: assert property (@(posedge clk) disable iff (!rstN)
      (strobe.macEn && !strobe.clrAcc && strobe.macRow == IDX_W'(r)
        && acc[r] == ACC_MIN && prod <= 0) |=> (acc[r] == ACC_MIN)); // R3

    AST_ACC_CLEARED: assert property (@(posedge clk) disable iff (!rstN)
      strobe.clrAcc |=> (acc[r] == '0)); // R2
  end

endmodule

// File: rtl/phase_unbal_est.sv
module phase_unbal_est
  import ue_pkg::*;
#(
  parameter int NPH   = 3,
  parameter int NBAND = 4,
  parameter int SW    = 10,
  parameter int CW    = 8,
  parameter int AW    = 18,
  parameter int SHW   = 3,
  localparam int NS   = 2 * NPH,
  localparam int BW   = (NBAND > 1) ? $clog2(NBAND) : 1,
  localparam int ADW  = $clog2(NS)
) (
  input  logic                 clk,
  input  logic                 rstN,
  input  logic                 start,
  input  logic [BW-1:0]        bandSel,
  input  logic [SHW-1:0]       shiftSel,
  output logic [ADW-1:0]       sampAddr,
  input  logic signed [SW-1:0] sampData,
  output logic                 busy,
  output logic                 done,
  output logic [NPH*AW-1:0]    estOut
);

  ueStrobe_t      strobe;
  logic [BW-1:0]  cfgBand;
  logic [SHW-1:0] cfgShift;

  ue_control #(
    .NPH  (NPH),
    .NBAND(NBAND),
    .SHW  (SHW)
  ) uCtrl (
    .clk     (clk),
    .rstN    (rstN),
    .start   (start),
    .bandSel (bandSel),
    .shiftSel(shiftSel),
    .strobe  (strobe),
    .cfgBand (cfgBand),
    .cfgShift(cfgShift),
    .sampAddr(sampAddr),
    .busy    (busy),
    .done    (done)
  );

  ue_datapath #(
    .NPH  (NPH),
    .NBAND(NBAND),
    .SW   (SW),
    .CW   (CW),
    .AW   (AW),
    .SHW  (SHW)
  ) uData (
    .clk     (clk),
    .rstN    (rstN),
    .strobe  (strobe),
    .cfgBand (cfgBand),
    .cfgShift(cfgShift),
    .sampData(sampData),
    .estFlat (estOut)
  );

endmodule

// File: tb/sim_phase_unbal_est.sv
module sim_phase_unbal_est;
  localparam int CLK_PERIOD = 10;
  localparam int NPH = 3;
  localparam int NS  = 2 * NPH;
  localparam int AW  = 18;
  localparam int LAT = NPH * NS + 2;
  localparam longint ACC_MAX = (longint'(1) << (AW - 1)) - 1;
  localparam longint ACC_MIN = -(longint'(1) << (AW - 1));

  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic start = 1'b0;
  logic [1:0] bandSel = '0;
  logic [2:0] shiftSel = '0;
  logic [2:0] sampAddr;
  logic signed [9:0] sampData;
  logic busy, done;
  logic [NPH*AW-1:0] estOut;

  logic signed [9:0] sampMem [NS];
  int nChecks = 0;
  int nFails = 0;
  longint yModel [NPH];
  int lcg = 7;

  always #(CLK_PERIOD/2) clk = ~clk;

  // sample buffer model: one cycle read latency
  always @(posedge clk) sampData <= sampMem[sampAddr];

  phase_unbal_est u0 (
    .clk(clk), .rstN(rstN), .start(start), .bandSel(bandSel), .shiftSel(shiftSel),
    .sampAddr(sampAddr), .sampData(sampData), .busy(busy), .done(done), .estOut(estOut)
  );

  function automatic int seedOf(int b, int r, int c);
    return (b * 37 + r * 23 + c * 11 + r * c * 5) % 128;
  endfunction

  function automatic int coefOf(int b, int r, int c);
    return seedOf(b, r, c) - seedOf(b, (r + 1) % NPH, c);
  endfunction

  function automatic longint rawOf(int b, int r);
    longint a = 0;
    for (int c = 0; c < NS; c++) begin
      a = a + longint'(coefOf(b, r, c)) * longint'(sampMem[c]);
      if (a > ACC_MAX) a = ACC_MAX;
      if (a < ACC_MIN) a = ACC_MIN;
    end
    return a;
  endfunction

  function automatic longint estOf(int p);
    logic signed [AW-1:0] v;
    v = estOut[p*AW +: AW];
    return longint'(v);
  endfunction

  task automatic check(input bit ok, input string req, input longint act, input longint exp);
    nChecks++;
    if (!ok) begin
      nFails++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  task automatic setPattern(input int k, input int b);
    for (int c = 0; c < NS; c++) begin
      case (k)
        0: sampMem[c] = 10'(c * 97 - 250);
        1: sampMem[c] = (c % 2 == 1) ? 10'sd400 : -10'sd300;
        2: begin
          lcg = lcg * 1103515245 + 12345;
          sampMem[c] = 10'((lcg >>> 16) % 512);
        end
        default: sampMem[c] = (c == b + 1) ? 10'sd300 : 10'sd0;
      endcase
    end
  endtask

  task automatic runEst(input int band, input int sh, input bit glitch, input string tag);
    longint raw [NPH];
    int addrBad = 0;
    int busyBad = 0;
    int doneCnt = 0;
    int doneAt = -1;
    for (int p = 0; p < NPH; p++) begin
      raw[p] = rawOf(band, p);
      yModel[p] = yModel[p] + ((raw[p] - yModel[p]) >>> sh);
    end
    @(negedge clk);
    bandSel = 2'(band); shiftSel = 3'(sh); start = 1'b1;
    @(posedge clk);
    for (int m = 0; m <= LAT + 1; m++) begin
      @(negedge clk);
      if (m < NPH * NS && int'(sampAddr) != m % NS) addrBad++;
      if (busy !== (m < LAT)) busyBad++;
      if (done === 1'b1) begin doneCnt++; doneAt = m; end
      if (m == LAT) begin
        for (int p = 0; p < NPH; p++)
          check(estOf(p) == yModel[p], tag, estOf(p), yModel[p]);
      end
      start = 1'b0; bandSel = 2'(band); shiftSel = 3'(sh);
      if (glitch && m >= 3 && m <= 6) begin
        start = 1'b1; bandSel = 2'(band + 1); shiftSel = 3'(sh + 5);
      end
      if (glitch && m >= 9 && m <= 12) begin
        bandSel = 2'(band + 2); shiftSel = 3'(sh + 1);
      end
    end
    check(addrBad == 0, "R10 address sweep", addrBad, 0);
    check(busyBad == 0, "R9 busy window", busyBad, 0);
    check(doneCnt == 1 && doneAt == LAT, "R6 done latency", doneAt, LAT);
    if (glitch) check(doneCnt == 1, "R7 single done", doneCnt, 1);
  endtask

  initial begin
    for (int p = 0; p < NPH; p++) yModel[p] = 0;
    for (int c = 0; c < NS; c++) sampMem[c] = '0;
    repeat (3) @(posedge clk);
    @(negedge clk);
    check(estOut == '0, "R1 outputs in reset", longint'(estOut[31:0]), 0);
    check(busy == 1'b0, "R1 busy in reset", busy, 0);
    check(done == 1'b0, "R1 done in reset", done, 0);
    rstN = 1'b1;
    repeat (2) @(negedge clk);
    check(estOut == '0 && !busy && !done, "R1 after release", longint'(estOut[31:0]), 0);

    // R2 / R8: every band, several patterns, no smoothing
    for (int b = 0; b < 4; b++) begin
      for (int k = 0; k < 4; k++) begin
        bit unsat = 1'b1;
        setPattern(k, b);
        for (int p = 0; p < NPH; p++) begin
          longint s = 0;
          for (int c = 0; c < NS; c++) s += longint'(coefOf(b, p, c)) * longint'(sampMem[c]);
          if (s > ACC_MAX || s < ACC_MIN) unsat = 1'b0;
        end
        runEst(b, 0, 1'b0, "R2 raw product");
        if (unsat)
          check(estOf(0) + estOf(1) + estOf(2) == 0, "R8 zero sum",
                estOf(0) + estOf(1) + estOf(2), 0);
      end
    end

    // R3: drive row 1 of band 0 into both rails
    for (int c = 0; c < NS; c++) sampMem[c] = (coefOf(0, 1, c) >= 0) ? 10'sd511 : -10'sd511;
    runEst(0, 0, 1'b0, "R3 saturate model");
    check(estOf(1) == ACC_MAX, "R3 positive rail", estOf(1), ACC_MAX);
    for (int c = 0; c < NS; c++) sampMem[c] = -sampMem[c];
    runEst(0, 0, 1'b0, "R3 saturate model");
    check(estOf(1) == ACC_MIN, "R3 negative rail", estOf(1), ACC_MIN);

    // R5: every shift amount, twice each so the filter state carries over
    for (int sh = 1; sh < 8; sh++) begin
      setPattern(2, 0);
      runEst(sh % 4, sh, 1'b0, "R5 filter step");
      setPattern(0, 0);
      runEst((sh + 1) % 4, sh, 1'b0, "R5 filter step");
    end

    // R4 / R7: config changes and start requests during a running estimate
    setPattern(1, 0);
    runEst(1, 2, 1'b1, "R4 R7 captured config");
    setPattern(3, 2);
    runEst(3, 0, 1'b1, "R4 R7 captured config");

    $display("End of test - %0d assertions evaluated, %0d failures", nChecks, nFails);
    $finish;
  end

  initial begin
    #(CLK_PERIOD * 200000);
    nChecks++;
    nFails++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("End of test - %0d assertions evaluated, %0d failures", nChecks, nFails);
    $finish;
  end

endmodule